// File: doc/BRIEF.md
# Filter Settling and Data-Ready Sequencer

This block decides when a delta-sigma conversion result may be announced to the host. A decimator supplies a one-cycle tick at the end of every conversion period, together with the finished 24-bit word. In steady state each tick loads that word and pulls a combined ready/data line low. A host that sees the line low raises its read select and clocks the word out, most significant bit first, on the same line.

When the host writes a new input channel or a new gain setting, the block sends a one-cycle reset pulse to the modulator and the filter. It drops any word not yet read and keeps the line high. A fourth-order sinc filter needs four full conversion periods before its output is valid. The block therefore ignores the first three ticks after the change and announces the result that arrives with the fourth. Another change during that window starts the count again.

A configuration bit can release the line to high impedance so that a second converter can share it. Sequencing continues internally while the line is released.

Top module: `settle_rdy_seq`

## Requirements
- R1: While reset is high, and after it, until the first load or shift, `rdy_sdo` is 1. During reset `rdy_sdo_oe` is 0 and `filt_rst` is 0.
- R2: Outside a settling window, a `conv_tick` captures `conv_word`, and `rdy_sdo` is 0 after that clock edge.
- R3: A cycle with `chan_wr` or `gain_wr` high gives `filt_rst` = 1 for exactly the next cycle. It also drives `rdy_sdo` to 1 and discards any unread word.
- R4: After a change, the first three `conv_tick` pulses leave `rdy_sdo` at 1, and the fourth loads its word and drives `rdy_sdo` to 0. A tick in the same cycle as a change is not counted.
- R5: A change that arrives during the settling window restarts the count, so that four more ticks are needed.
- R6: While `rd_sel` is 1 and a word is ready, the k-th rising edge of `sclk` (k = 1..24) places bit 24-k of the word on `rdy_sdo`. This happens at the clock edge after `sclk` is first seen high, so the bits come out most significant first.
- R7: After the 24th bit the word is no longer ready. Further `sclk` edges leave `rdy_sdo` unchanged, and `rdy_sdo` returns to 1 one cycle after `rd_sel` goes to 0.
- R8: A load while an unread or partly read word is held overwrites it. `rdy_sdo` goes back to 0 and the next read starts again at the most significant bit.
- R9: `sclk` edges while `rd_sel` is 0 have no effect, and `rdy_sdo` stays 0.
- R10: `rdy_sdo_oe` equals the inverse of `out_hiz`, delayed by one cycle. Loading and settling continue while the line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| conv_tick | input | 1 | One-cycle pulse at the end of each conversion period |
| conv_word | input | 24 | Conversion result, valid with `conv_tick` |
| chan_wr | input | 1 | Strobe: a new input channel was written |
| gain_wr | input | 1 | Strobe: a new gain setting was written |
| out_hiz | input | 1 | 1 = release the ready/data line to high impedance |
| rd_sel | input | 1 | Host read select, active high |
| sclk | input | 1 | Serial clock, synchronous to `clk`; rising edges shift data |
| rdy_sdo | output | 1 | Ready (low) and serial data line |
| rdy_sdo_oe | output | 1 | Drive enable for `rdy_sdo` |
| filt_rst | output | 1 | One-cycle reset to the modulator and filter |

## Verification
If the settle counter is wrong, the line falls too early or too late. The error shows at the port in the cycle after the third or the fifth tick that follows a change, not after the fourth. If the shift register or the bit counter is wrong, the error shows within one serial-clock edge as a wrong bit, or as a line that does not go high when read select drops after 24 bits. A lost or stale word shows as a mismatch against the word that came with the latest announced tick.

// File: rtl/settle_rdy_pkg.sv
package settle_rdy_pkg;
  parameter int unsigned RES_W_DEF  = 24;
  parameter int unsigned SETTLE_DEF = 4;

  // width of a counter that must hold 0..n
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/sclk_rise.sv
module sclk_rise (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  output logic rise
);
  logic sclk_q;

  always_ff @(posedge clk) begin
    if (rst) sclk_q <= 1'b1;
    else     sclk_q <= sclk;
  end

  assign rise = sclk & ~sclk_q;
endmodule

// File: rtl/settle_ctl.sv
module settle_ctl #(
  parameter int unsigned SETTLE = settle_rdy_pkg::SETTLE_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic chg,
  output logic load,
  output logic filt_rst
);
  localparam int unsigned CW = settle_rdy_pkg::cnt_w(SETTLE);

  logic [CW-1:0] cnt;
  logic          busy;
  logic          last;

  assign last = (cnt == CW'(SETTLE - 1));
  // a change in the same cycle as a tick wins; the tick is not counted
  assign load = tick & ~chg & (~busy | last);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      cnt      <= '0;
      filt_rst <= 1'b0;
    end else begin
      filt_rst <= chg;
      if (chg) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (tick && busy) begin
        if (last) busy <= 1'b0;
        else      cnt  <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/serial_out.sv
module serial_out #(
  parameter int unsigned W = settle_rdy_pkg::RES_W_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         rd_sel,
  input  logic         rise,
  output logic         sdo,
  output logic         rdy,
  output logic [settle_rdy_pkg::cnt_w(W)-1:0] nb
);
  localparam int unsigned NBW = settle_rdy_pkg::cnt_w(W);

  logic [W-1:0]   sh, sh_n;
  logic           sdo_n, rdy_n;
  logic [NBW-1:0] nb_n;

  always_comb begin
    sh_n  = sh;
    sdo_n = sdo;
    rdy_n = rdy;
    nb_n  = nb;
    if (clr) begin
      sdo_n = 1'b1;
      rdy_n = 1'b0;
      nb_n  = '0;
    end else if (load) begin
      sh_n  = din;
      sdo_n = 1'b0;
      rdy_n = 1'b1;
      nb_n  = '0;
    end else if (rd_sel && rdy && rise) begin
      sdo_n = sh[W-1];
      sh_n  = {sh[W-2:0], 1'b0};
      nb_n  = nb + 1'b1;
      if (nb == NBW'(W - 1)) rdy_n = 1'b0;
    end else if (!rd_sel && !rdy) begin
      sdo_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh  <= '0;
      sdo <= 1'b1;
      rdy <= 1'b0;
      nb  <= '0;
    end else begin
      sh  <= sh_n;
      sdo <= sdo_n;
      rdy <= rdy_n;
      nb  <= nb_n;
    end
  end
endmodule

// File: rtl/settle_rdy_seq.sv
module settle_rdy_seq #(
  parameter int unsigned W      = settle_rdy_pkg::RES_W_DEF,
  parameter int unsigned SETTLE = settle_rdy_pkg::SETTLE_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         conv_tick,
  input  logic [W-1:0] conv_word,
  input  logic         chan_wr,
  input  logic         gain_wr,
  input  logic         out_hiz,
  input  logic         rd_sel,
  input  logic         sclk,
  output logic         rdy_sdo,
  output logic         rdy_sdo_oe,
  output logic         filt_rst
);
  localparam int unsigned NBW = settle_rdy_pkg::cnt_w(W);

  logic           chg;
  logic           load;
  logic           rise;
  logic           word_rdy;
  logic [NBW-1:0] bit_cnt;

  assign chg = chan_wr | gain_wr;

  settle_ctl #(.SETTLE(SETTLE)) u_settle (
    .clk      (clk),
    .rst      (rst),
    .tick     (conv_tick),
    .chg      (chg),
    .load     (load),
    .filt_rst (filt_rst)
  );

  sclk_rise u_edge (
    .clk  (clk),
    .rst  (rst),
    .sclk (sclk),
    .rise (rise)
  );

  serial_out #(.W(W)) u_out (
    .clk    (clk),
    .rst    (rst),
    .clr    (chg),
    .load   (load),
    .din    (conv_word),
    .rd_sel (rd_sel),
    .rise   (rise),
    .sdo    (rdy_sdo),
    .rdy    (word_rdy),
    .nb     (bit_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) rdy_sdo_oe <= 1'b0;
    else     rdy_sdo_oe <= ~out_hiz;
  end
endmodule

// File: rtl/settle_rdy_chk.sv
module settle_rdy_chk #(
  parameter int unsigned W      = 24,
  parameter int unsigned SETTLE = 4,
  parameter int unsigned NBW    = 5
) (
  input logic           clk,
  input logic           rst,
  input logic           conv_tick,
  input logic           chan_wr,
  input logic           gain_wr,
  input logic           out_hiz,
  input logic           rdy_sdo,
  input logic           rdy_sdo_oe,
  input logic           filt_rst,
  input logic           word_rdy,
  input logic [NBW-1:0] bit_cnt
);
  localparam int unsigned TW = settle_rdy_pkg::cnt_w(SETTLE);

  logic          chg;
  logic [TW-1:0] since;

  assign chg = chan_wr | gain_wr;

  // ticks seen since the last change, saturating at SETTLE
  always_ff @(posedge clk) begin
    if (rst)                                    since <= TW'(SETTLE);
    else if (chg)                               since <= '0;
    else if (conv_tick && since < TW'(SETTLE))  since <= since + 1'b1;
  end

  // R4
  settle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (since < TW'(SETTLE)) |-> (!word_rdy && rdy_sdo));

  // R3
  filt_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    chg |=> (filt_rst && rdy_sdo && !word_rdy));

  // R3
  filt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !chg |=> !filt_rst);

  // R10
  oe_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (rdy_sdo_oe == !$past(out_hiz)));

  // R7
  bit_bound_chk: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= NBW'(W));

  // R2
  ready_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(word_rdy) |-> !rdy_sdo);
endmodule

bind settle_rdy_seq settle_rdy_chk #(.W(W), .SETTLE(SETTLE), .NBW(NBW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .conv_tick  (conv_tick),
  .chan_wr    (chan_wr),
  .gain_wr    (gain_wr),
  .out_hiz    (out_hiz),
  .rdy_sdo    (rdy_sdo),
  .rdy_sdo_oe (rdy_sdo_oe),
  .filt_rst   (filt_rst),
  .word_rdy   (word_rdy),
  .bit_cnt    (bit_cnt)
);

// File: tb/tb_settle_rdy_seq.sv
`timescale 1ns/1ps
module tb_settle_rdy_seq;
  localparam int W = 24;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         conv_tick = 1'b0;
  logic [W-1:0] conv_word = '0;
  logic         chan_wr = 1'b0;
  logic         gain_wr = 1'b0;
  logic         out_hiz = 1'b1;
  logic         rd_sel = 1'b0;
  logic         sclk = 1'b0;
  logic         rdy_sdo, rdy_sdo_oe, filt_rst;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #2.5 clk = ~clk;

  settle_rdy_seq dut (
    .clk(clk), .rst(rst), .conv_tick(conv_tick), .conv_word(conv_word),
    .chan_wr(chan_wr), .gain_wr(gain_wr), .out_hiz(out_hiz),
    .rd_sel(rd_sel), .sclk(sclk),
    .rdy_sdo(rdy_sdo), .rdy_sdo_oe(rdy_sdo_oe), .filt_rst(filt_rst)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock: the design updates at posedge, outputs are sampled at negedge
  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic tick(input logic [W-1:0] d);
    conv_word = d; conv_tick = 1'b1;
    cyc();
    conv_tick = 1'b0;
  endtask

  task automatic change(input bit gain);
    if (gain) gain_wr = 1'b1; else chan_wr = 1'b1;
    cyc();
    chan_wr = 1'b0; gain_wr = 1'b0;
  endtask

  task automatic shift_bits(input int n, output logic [W-1:0] got);
    got = '0;
    rd_sel = 1'b1;
    for (int i = 0; i < n; i++) begin
      sclk = 1'b1; cyc();
      got = {got[W-2:0], rdy_sdo};
      sclk = 1'b0; cyc();
    end
  endtask

  task automatic read_check(input logic [W-1:0] exp, input string tag);
    logic [W-1:0] got;
    shift_bits(W, got);
    chk(got == exp, tag, 32'(got), 32'(exp));
    sclk = 1'b1; cyc(); sclk = 1'b0; cyc();
    chk(rdy_sdo == exp[0], "R7 line held after 24th bit", 32'(rdy_sdo), 32'(exp[0]));
    rd_sel = 1'b0; cyc();
    chk(rdy_sdo == 1'b1, "R7 line high after read", 32'(rdy_sdo), 32'h1);
  endtask

  task automatic t_reset();
    rst = 1'b1; cyc(); cyc();
    chk(rdy_sdo == 1'b1, "R1 line high in reset", 32'(rdy_sdo), 32'h1);
    chk(rdy_sdo_oe == 1'b0, "R1 oe low in reset", 32'(rdy_sdo_oe), 32'h0);
    chk(filt_rst == 1'b0, "R1 filt_rst low in reset", 32'(filt_rst), 32'h0);
    rst = 1'b0; out_hiz = 1'b0; cyc();
    chk(rdy_sdo_oe == 1'b1, "R10 oe follows out_hiz", 32'(rdy_sdo_oe), 32'h1);
    chk(rdy_sdo == 1'b1, "R1 line high before first load", 32'(rdy_sdo), 32'h1);
  endtask

  task automatic t_steady();
    tick(24'hA5C3_96);
    chk(rdy_sdo == 1'b0, "R2 ready after tick", 32'(rdy_sdo), 32'h0);
    read_check(24'hA5C396, "R6 read pattern 1");
    tick(24'h0F_F001);
    chk(rdy_sdo == 1'b0, "R2 ready after second tick", 32'(rdy_sdo), 32'h0);
    read_check(24'h0FF001, "R6 read pattern 2");
  endtask

  task automatic t_sclk_ignored();
    tick(24'h81_2345);
    rd_sel = 1'b0;
    for (int i = 0; i < 3; i++) begin
      sclk = 1'b1; cyc(); sclk = 1'b0; cyc();
    end
    chk(rdy_sdo == 1'b0, "R9 sclk ignored without rd_sel", 32'(rdy_sdo), 32'h0);
    read_check(24'h812345, "R9 word intact after ignored sclk");
  endtask

  task automatic t_change(input bit gain, input logic [W-1:0] w4);
    tick(24'h55_5555);
    change(gain);
    chk(filt_rst == 1'b1, "R3 filt_rst pulse", 32'(filt_rst), 32'h1);
    chk(rdy_sdo == 1'b1, "R3 pending word dropped", 32'(rdy_sdo), 32'h1);
    cyc();
    chk(filt_rst == 1'b0, "R3 filt_rst one cycle", 32'(filt_rst), 32'h0);
    for (int i = 0; i < 3; i++) begin
      tick(24'h11_1111);
      chk(rdy_sdo == 1'b1, "R4 early tick suppressed", 32'(rdy_sdo), 32'h1);
    end
    tick(w4);
    chk(rdy_sdo == 1'b0, "R4 ready on fourth tick", 32'(rdy_sdo), 32'h0);
    read_check(w4, "R4 settled word");
  endtask

  task automatic t_restart();
    change(1'b0);
    tick(24'h1); tick(24'h2);
    change(1'b1);
    for (int i = 0; i < 3; i++) begin
      tick(24'h3);
      chk(rdy_sdo == 1'b1, "R5 count restarted", 32'(rdy_sdo), 32'h1);
    end
    tick(24'hC0_FFEE);
    chk(rdy_sdo == 1'b0, "R5 ready after restart", 32'(rdy_sdo), 32'h0);
    read_check(24'hC0FFEE, "R5 word after restart");
  endtask

  task automatic t_same_cycle();
    conv_word = 24'h77_7777; conv_tick = 1'b1; chan_wr = 1'b1;
    cyc();
    conv_tick = 1'b0; chan_wr = 1'b0;
    chk(rdy_sdo == 1'b1, "R4 change beats tick", 32'(rdy_sdo), 32'h1);
    for (int i = 0; i < 3; i++) begin
      tick(24'h4);
      chk(rdy_sdo == 1'b1, "R4 same-cycle tick not counted", 32'(rdy_sdo), 32'h1);
    end
    tick(24'h3C_A5A5);
    chk(rdy_sdo == 1'b0, "R4 ready on fourth counted tick", 32'(rdy_sdo), 32'h0);
    read_check(24'h3CA5A5, "R4 word after same-cycle change");
  endtask

  task automatic t_overwrite();
    logic [W-1:0] part;
    tick(24'hDE_AD01);
    tick(24'hBE_EF02);
    read_check(24'hBEEF02, "R8 unread word overwritten");
    tick(24'hF0_0F0F);
    shift_bits(5, part);
    chk(part[4:0] == 5'b11110, "R6 partial read bits", 32'(part[4:0]), 32'h1E);
    tick(24'h96_1234);
    chk(rdy_sdo == 1'b0, "R8 ready again after overwrite", 32'(rdy_sdo), 32'h0);
    read_check(24'h961234, "R8 read restarts at MSB");
  endtask

  task automatic t_hiz();
    out_hiz = 1'b1; cyc();
    chk(rdy_sdo_oe == 1'b0, "R10 line released", 32'(rdy_sdo_oe), 32'h0);
    change(1'b0);
    for (int i = 0; i < 4; i++) tick(24'h6B_0D15);
    out_hiz = 1'b0; cyc();
    chk(rdy_sdo_oe == 1'b1, "R10 line driven again", 32'(rdy_sdo_oe), 32'h1);
    chk(rdy_sdo == 1'b0, "R10 settling ran while released", 32'(rdy_sdo), 32'h0);
    read_check(24'h6B0D15, "R10 word after release");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_steady();
    t_sclk_ignored();
    t_change(1'b0, 24'h2468AC);
    t_change(1'b1, 24'hF13579);
    t_restart();
    t_same_cycle();
    t_overwrite();
    t_hiz();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule